// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

This block takes a stream of instruction bytes, one per valid/ready transfer, and splits each instruction into its fields. Those fields are any leading prefix bytes, a one- or two-byte opcode, an optional operand-form byte, an optional scaled-index byte, a displacement and an immediate. How many bytes follow the opcode depends on the data. A small class input, driven by the surrounding logic alongside each byte, says whether the opcode takes an operand-form byte and how wide its immediate is. The parser samples that input only on the final opcode byte. The field values of the operand-form and scaled-index bytes then decide whether more bytes follow.

When the last byte of an instruction is accepted, the parser pulses `done_o` on the next cycle. For that one cycle it presents a record: the decoded fields, the total length and two flags. One flag marks a repeated prefix group. The other marks an instruction that ran past the maximum length. The record holds its values until the first byte of the next instruction is accepted. The parser accepts a new byte in the same cycle it presents a record, so instructions can stream back to back.

Top module: `ipx_len_parser`

## Requirements
- R1: Byte values 26h, 2Eh, 36h, 3Eh, 64h and 65h are segment prefixes. They set `seg_valid_o` and give `seg_sel_o` the values 0 to 5 in that order. 66h sets `opsize_o` and 67h sets `adsize_o`. Prefixes may come in any order before the opcode.
- R2: `redundant_o` is 1 when a second prefix from an already-seen group (segment, 66h or 67h) arrives within the same instruction. For the segment group, the later prefix sets `seg_sel_o`.
- R3: An opcode byte of 0Fh is an escape. The next byte becomes `opcode_o` and `two_byte_o` is set.
- R4: The class input is sampled on the final opcode byte. `cls_form_i`=1 means one operand-form byte follows; its mode field is bits 7:6 and its register/memory field is bits 2:0. A mode field of 11b adds no scaled-index byte and no displacement.
- R5: Under 32-bit addressing, an operand-form byte with register/memory field 100b and mode field other than 11b is followed by one scaled-index byte.
- R6: The displacement is 1 byte for mode 01b. For mode 10b it is 4 bytes under 32-bit addressing and 2 bytes under 16-bit addressing. For mode 00b it is 4 bytes when the register/memory field is 101b under 32-bit addressing, or 2 bytes when it is 110b under 16-bit addressing. Otherwise there is none.
- R7: When a scaled-index byte is present, mode 00b with a base field (bits 2:0 of that byte) of 101b gives a 4-byte displacement. Mode 01b and 10b give 1 and 4 bytes.
- R8: The immediate follows all displacement bytes. Its size comes from `cls_imm_i` (0 none, 1 one byte, 2 two bytes, 3 four bytes). Displacement and immediate are assembled little-endian, zero above their lengths.
- R9: `mode32_i`=1 selects 32-bit addressing by default. A 67h prefix inverts that for the current instruction only. `addr32_o` reports the addressing size in effect.
- R10: `done_o` is high for exactly one cycle, the cycle after the final byte of an instruction is accepted. At that time `len_o` is the total byte count.
- R11: If an instruction is still incomplete after `MAX_LEN` (15) bytes, the parser reports `done_o` with `err_len_o`=1 and `len_o`=15. The next accepted byte starts a new instruction.
- R12: During reset `byte_ready_o` and `done_o` are 0. After reset `byte_ready_o` is 1.
- R13: Cycles with `byte_valid_i` low change no state, whatever `byte_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode32_i | input | 1 | Default addressing size, 1 = 32-bit |
| byte_valid_i | input | 1 | Byte transfer request |
| byte_i | input | 8 | Instruction byte |
| cls_form_i | input | 1 | Opcode class: operand-form byte follows |
| cls_imm_i | input | 2 | Opcode class: immediate size code |
| byte_ready_o | output | 1 | Parser can take a byte |
| done_o | output | 1 | Record valid, one-cycle pulse |
| err_len_o | output | 1 | Instruction exceeded maximum length |
| redundant_o | output | 1 | Repeated prefix group seen |
| len_o | output | 4 | Instruction length in bytes |
| seg_valid_o | output | 1 | Segment prefix present |
| seg_sel_o | output | 3 | Segment prefix index |
| opsize_o | output | 1 | 66h prefix present |
| adsize_o | output | 1 | 67h prefix present |
| addr32_o | output | 1 | Effective 32-bit addressing |
| two_byte_o | output | 1 | Opcode was escaped |
| opcode_o | output | 8 | Final opcode byte |
| form_valid_o | output | 1 | Operand-form byte present |
| form_o | output | 8 | Operand-form byte |
| sx_valid_o | output | 1 | Scaled-index byte present |
| sx_o | output | 8 | Scaled-index byte |
| disp_len_o | output | 3 | Displacement length in bytes |
| disp_o | output | 32 | Displacement, little-endian |
| imm_len_o | output | 3 | Immediate length in bytes |
| imm_o | output | 32 | Immediate, little-endian |

## Verification
Every record result is due exactly one cycle after the final byte's transfer edge. That covers the done pulse, the length, both flags and all fields. No result appears earlier or later. The bench sends one byte per cycle and samples at the falling edge after each transfer. It expects `done_o` low after every byte but the last, including idle cycles, and expects the full record after the last byte. The expected length and fields come from a behavioural walk over the byte list, made before the bytes are sent. For over-length cases the bench sends only the first 15 bytes, and it checks that the record appears after the fifteenth.

// File: rtl/ipx_pkg.sv
package ipx_pkg;
  localparam int unsigned FLD_W = 32;

  typedef enum logic [2:0] {
    ST_PFX, ST_OP2, ST_FORM, ST_SX, ST_DISP, ST_IMM
  } pst_e;

  typedef struct packed {
    logic             redundant;
    logic             seg_valid;
    logic [2:0]       seg_sel;
    logic             opsize;
    logic             adsize;
    logic             addr32;
    logic             two_byte;
    logic [7:0]       opcode;
    logic             form_valid;
    logic [7:0]       form;
    logic             sx_valid;
    logic [7:0]       sx;
    logic [2:0]       disp_len;
    logic [FLD_W-1:0] disp;
    logic [2:0]       imm_len;
    logic [FLD_W-1:0] imm;
  } insn_rec_t;

  function automatic logic [2:0] imm_size(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ipx_prefix_dec.sv
module ipx_prefix_dec (
  input  logic [7:0] byte_i,
  output logic       seg_o,
  output logic [2:0] seg_sel_o,
  output logic       opsz_o,
  output logic       adsz_o
);
  always_comb begin
    seg_o     = 1'b1;
    seg_sel_o = 3'd0;
    unique case (byte_i)
      8'h26:   seg_sel_o = 3'd0;
      8'h2E:   seg_sel_o = 3'd1;
      8'h36:   seg_sel_o = 3'd2;
      8'h3E:   seg_sel_o = 3'd3;
      8'h64:   seg_sel_o = 3'd4;
      8'h65:   seg_sel_o = 3'd5;
      default: seg_o = 1'b0;
    endcase
    opsz_o = (byte_i == 8'h66);
    adsz_o = (byte_i == 8'h67);
  end
endmodule

// File: rtl/ipx_form_dec.sv
module ipx_form_dec (
  input  logic [7:0] form_i,
  input  logic       addr32_i,
  output logic       sx_o,
  output logic [2:0] disp_len_o
);
  logic [1:0] md;
  logic [2:0] rm;
  assign md = form_i[7:6];
  assign rm = form_i[2:0];

  always_comb begin
    sx_o       = 1'b0;
    disp_len_o = 3'd0;
    unique case (md)
      2'b00: begin
        if (addr32_i) begin
          sx_o       = (rm == 3'b100);
          disp_len_o = (rm == 3'b101) ? 3'd4 : 3'd0;
        end else begin
          disp_len_o = (rm == 3'b110) ? 3'd2 : 3'd0;
        end
      end
      2'b01: begin
        sx_o       = addr32_i && (rm == 3'b100);
        disp_len_o = 3'd1;
      end
      2'b10: begin
        sx_o       = addr32_i && (rm == 3'b100);
        disp_len_o = addr32_i ? 3'd4 : 3'd2;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ipx_sx_dec.sv
module ipx_sx_dec (
  input  logic [1:0] mode_i,
  input  logic [2:0] base_i,
  output logic [2:0] disp_len_o
);
  always_comb begin
    unique case (mode_i)
      2'b00:   disp_len_o = (base_i == 3'b101) ? 3'd4 : 3'd0;
      2'b01:   disp_len_o = 3'd1;
      2'b10:   disp_len_o = 3'd4;
      default: disp_len_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/ipx_len_parser.sv
module ipx_len_parser #(
  parameter int unsigned MAX_LEN = 15
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           mode32_i,
  input  logic                           byte_valid_i,
  input  logic [7:0]                     byte_i,
  input  logic                           cls_form_i,
  input  logic [1:0]                     cls_imm_i,
  output logic                           byte_ready_o,
  output logic                           done_o,
  output logic                           err_len_o,
  output logic                           redundant_o,
  output logic [$clog2(MAX_LEN+1)-1:0]   len_o,
  output logic                           seg_valid_o,
  output logic [2:0]                     seg_sel_o,
  output logic                           opsize_o,
  output logic                           adsize_o,
  output logic                           addr32_o,
  output logic                           two_byte_o,
  output logic [7:0]                     opcode_o,
  output logic                           form_valid_o,
  output logic [7:0]                     form_o,
  output logic                           sx_valid_o,
  output logic [7:0]                     sx_o,
  output logic [2:0]                     disp_len_o,
  output logic [31:0]                    disp_o,
  output logic [2:0]                     imm_len_o,
  output logic [31:0]                    imm_o
);
  import ipx_pkg::*;
  localparam int unsigned LEN_W = $clog2(MAX_LEN + 1);

  pst_e             state_q, state_base, state_n;
  insn_rec_t        rec_q, rec_base, rec_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [2:0]       rem_q, rem_n, immp_q, immp_n;
  logic [1:0]       fidx_q, fidx_n;
  logic             fresh_q, done_q, err_q, ready_q;
  logic             acc, fin, over, op_take, to_disp, to_imm;
  logic [2:0]       dlen;

  logic       pd_seg, pd_opsz, pd_adsz;
  logic [2:0] pd_sel;
  logic       fd_sx;
  logic [2:0] fd_dl, sd_dl;

  ipx_prefix_dec u_pfx (
    .byte_i(byte_i), .seg_o(pd_seg), .seg_sel_o(pd_sel),
    .opsz_o(pd_opsz), .adsz_o(pd_adsz)
  );

  ipx_form_dec u_form (
    .form_i(byte_i), .addr32_i(rec_base.addr32),
    .sx_o(fd_sx), .disp_len_o(fd_dl)
  );

  ipx_sx_dec u_sx (
    .mode_i(rec_base.form[7:6]), .base_i(byte_i[2:0]), .disp_len_o(sd_dl)
  );

  always_comb begin
    acc        = byte_valid_i & ready_q;
    rec_base   = fresh_q ? '0 : rec_q;
    state_base = fresh_q ? ST_PFX : state_q;
    cnt_n      = (fresh_q ? '0 : cnt_q) + LEN_W'(1);
    rec_n      = rec_base;
    state_n    = state_base;
    rem_n      = rem_q;
    fidx_n     = fidx_q;
    immp_n     = immp_q;
    fin        = 1'b0;
    op_take    = 1'b0;
    to_disp    = 1'b0;
    to_imm     = 1'b0;
    dlen       = 3'd0;

    unique case (state_base)
      ST_PFX: begin
        if (pd_seg || pd_opsz || pd_adsz) begin
          if (pd_seg) begin
            if (rec_base.seg_valid) rec_n.redundant = 1'b1;
            rec_n.seg_valid = 1'b1;
            rec_n.seg_sel   = pd_sel;
          end
          if (pd_opsz) begin
            if (rec_base.opsize) rec_n.redundant = 1'b1;
            rec_n.opsize = 1'b1;
          end
          if (pd_adsz) begin
            if (rec_base.adsize) rec_n.redundant = 1'b1;
            rec_n.adsize = 1'b1;
          end
        end else if (byte_i == 8'h0F) begin
          rec_n.two_byte = 1'b1;
          state_n        = ST_OP2;
        end else begin
          op_take = 1'b1;
        end
      end
      ST_OP2: op_take = 1'b1;
      ST_FORM: begin
        rec_n.form = byte_i;
        if (fd_sx) state_n = ST_SX;
        else if (fd_dl != 3'd0) begin
          to_disp = 1'b1;
          dlen    = fd_dl;
        end else to_imm = 1'b1;
      end
      ST_SX: begin
        rec_n.sx_valid = 1'b1;
        rec_n.sx       = byte_i;
        if (sd_dl != 3'd0) begin
          to_disp = 1'b1;
          dlen    = sd_dl;
        end else to_imm = 1'b1;
      end
      ST_DISP: begin
        rec_n.disp[{fidx_q, 3'b000} +: 8] = byte_i;
        fidx_n = fidx_q + 2'd1;
        rem_n  = rem_q - 3'd1;
        if (rem_q == 3'd1) to_imm = 1'b1;
      end
      ST_IMM: begin
        rec_n.imm[{fidx_q, 3'b000} +: 8] = byte_i;
        fidx_n = fidx_q + 2'd1;
        rem_n  = rem_q - 3'd1;
        if (rem_q == 3'd1) fin = 1'b1;
      end
      default: ;
    endcase

    // class input only matters on the final opcode byte
    if (op_take) begin
      rec_n.opcode = byte_i;
      rec_n.addr32 = mode32_i ^ rec_base.adsize;
      immp_n       = imm_size(cls_imm_i);
      if (cls_form_i) begin
        rec_n.form_valid = 1'b1;
        state_n          = ST_FORM;
      end else to_imm = 1'b1;
    end
    if (to_disp) begin
      rec_n.disp_len = dlen;
      rem_n          = dlen;
      fidx_n         = 2'd0;
      state_n        = ST_DISP;
    end
    if (to_imm) begin
      rec_n.imm_len = immp_n;
      if (immp_n == 3'd0) fin = 1'b1;
      else begin
        rem_n   = immp_n;
        fidx_n  = 2'd0;
        state_n = ST_IMM;
      end
    end
    over = !fin && (cnt_n == LEN_W'(MAX_LEN));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PFX;
      rec_q   <= '0;
      cnt_q   <= '0;
      rem_q   <= '0;
      immp_q  <= '0;
      fidx_q  <= '0;
      fresh_q <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= acc && (fin || over);
      if (acc) begin
        rec_q   <= rec_n;
        cnt_q   <= cnt_n;
        rem_q   <= rem_n;
        immp_q  <= immp_n;
        fidx_q  <= fidx_n;
        state_q <= (fin || over) ? ST_PFX : state_n;
        fresh_q <= fin || over;
        err_q   <= over;
      end
    end
  end

  assign byte_ready_o = ready_q;
  assign done_o       = done_q;
  assign err_len_o    = err_q;
  assign len_o        = cnt_q;
  assign redundant_o  = rec_q.redundant;
  assign seg_valid_o  = rec_q.seg_valid;
  assign seg_sel_o    = rec_q.seg_sel;
  assign opsize_o     = rec_q.opsize;
  assign adsize_o     = rec_q.adsize;
  assign addr32_o     = rec_q.addr32;
  assign two_byte_o   = rec_q.two_byte;
  assign opcode_o     = rec_q.opcode;
  assign form_valid_o = rec_q.form_valid;
  assign form_o       = rec_q.form;
  assign sx_valid_o   = rec_q.sx_valid;
  assign sx_o         = rec_q.sx;
  assign disp_len_o   = rec_q.disp_len;
  assign disp_o       = rec_q.disp;
  assign imm_len_o    = rec_q.imm_len;
  assign imm_o        = rec_q.imm;

  assert_done_after_byte_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(byte_valid_i && byte_ready_o));

  assert_err_full_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_len_o) |-> (len_o == LEN_W'(MAX_LEN)));

  assert_no_form_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_len_o && !form_valid_o) |-> (!sx_valid_o && disp_len_o == 3'd0));

  assert_reg_form_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_len_o && form_valid_o && form_o[7:6] == 2'b11)
      |-> (!sx_valid_o && disp_len_o == 3'd0));

  assert_sx_mem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_len_o && sx_valid_o)
      |-> (addr32_o && form_o[2:0] == 3'b100 && form_o[7:6] != 2'b11));

  assert_disp16_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_len_o && !addr32_o) |-> (disp_len_o != 3'd4));

  assert_imm_size_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_len_o) |-> ($countones(imm_len_o) <= 1));

  assert_ready_reset_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(byte_ready_o) |-> byte_ready_o);
endmodule

// File: tb/sim_ipx_len_parser.sv
`timescale 1ns/1ps
module sim_ipx_len_parser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m32 = 1'b1;
  logic bv = 1'b0;
  logic [7:0] bd = 8'h00;
  logic cm;
  logic [1:0] ci;

  logic byte_ready_o, done_o, err_len_o, redundant_o;
  logic [3:0] len_o;
  logic seg_valid_o, opsize_o, adsize_o, addr32_o, two_byte_o;
  logic [2:0] seg_sel_o, disp_len_o, imm_len_o;
  logic [7:0] opcode_o, form_o, sx_o;
  logic form_valid_o, sx_valid_o;
  logic [31:0] disp_o, imm_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // bench opcode class table: {form, imm code}
  function automatic logic [2:0] cls_of(input logic [7:0] b);
    case (b)
      8'h89, 8'h8B, 8'hAF: return 3'b100;
      8'h81, 8'hC7:        return 3'b111;
      8'h83:               return 3'b101;
      8'h04:               return 3'b001;
      8'h05, 8'h84:        return 3'b011;
      8'hC2:               return 3'b010;
      default:             return 3'b000;
    endcase
  endfunction

  assign {cm, ci} = cls_of(bd);

  ipx_len_parser u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode32_i(m32), .byte_valid_i(bv), .byte_i(bd),
    .cls_form_i(cm), .cls_imm_i(ci), .byte_ready_o(byte_ready_o), .done_o(done_o),
    .err_len_o(err_len_o), .redundant_o(redundant_o), .len_o(len_o),
    .seg_valid_o(seg_valid_o), .seg_sel_o(seg_sel_o), .opsize_o(opsize_o),
    .adsize_o(adsize_o), .addr32_o(addr32_o), .two_byte_o(two_byte_o),
    .opcode_o(opcode_o), .form_valid_o(form_valid_o), .form_o(form_o),
    .sx_valid_o(sx_valid_o), .sx_o(sx_o), .disp_len_o(disp_len_o), .disp_o(disp_o),
    .imm_len_o(imm_len_o), .imm_o(imm_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  logic [7:0] pk [0:31];
  int e_len, e_dl, e_il;
  bit e_err, e_red, e_segv, e_ops, e_ads, e_a32, e_two, e_fv, e_sv;
  logic [2:0] e_sel;
  logic [7:0] e_op, e_f, e_s;
  logic [31:0] e_d, e_i;

  // behavioural walk over the byte list
  task automatic model(input bit mode);
    int p;
    logic [2:0] c;
    logic [1:0] md;
    e_red = 0; e_segv = 0; e_sel = 0; e_ops = 0; e_ads = 0; e_two = 0;
    e_fv = 0; e_f = 0; e_sv = 0; e_s = 0; e_dl = 0; e_d = 0; e_il = 0; e_i = 0;
    p = 0;
    while (p < 20) begin
      case (pk[p])
        8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: begin
          if (e_segv) e_red = 1;
          e_segv = 1;
          case (pk[p])
            8'h26: e_sel = 0; 8'h2E: e_sel = 1; 8'h36: e_sel = 2;
            8'h3E: e_sel = 3; 8'h64: e_sel = 4; default: e_sel = 5;
          endcase
        end
        8'h66: begin if (e_ops) e_red = 1; e_ops = 1; end
        8'h67: begin if (e_ads) e_red = 1; e_ads = 1; end
        default: break;
      endcase
      p++;
    end
    if (pk[p] == 8'h0F) begin e_two = 1; p++; end
    e_op = pk[p]; p++;
    e_a32 = mode ^ e_ads;
    c = cls_of(e_op);
    e_il = (c[1:0] == 0) ? 0 : (c[1:0] == 1) ? 1 : (c[1:0] == 2) ? 2 : 4;
    if (c[2]) begin
      e_fv = 1; e_f = pk[p]; p++;
      md = e_f[7:6];
      if (md != 2'b11) begin
        if (e_a32) begin
          if (e_f[2:0] == 3'b100) begin
            e_sv = 1; e_s = pk[p]; p++;
            e_dl = (md == 1) ? 1 : (md == 2) ? 4 : (e_s[2:0] == 3'b101) ? 4 : 0;
          end else e_dl = (md == 1) ? 1 : (md == 2) ? 4 : (e_f[2:0] == 3'b101) ? 4 : 0;
        end else e_dl = (md == 1) ? 1 : (md == 2) ? 2 : (e_f[2:0] == 3'b110) ? 2 : 0;
      end
    end
    for (int j = 0; j < e_dl; j++) e_d[8*j +: 8] = pk[p+j];
    p += e_dl;
    for (int j = 0; j < e_il; j++) e_i[8*j +: 8] = pk[p+j];
    p += e_il;
    e_err = (p > 15);
    e_len = e_err ? 15 : p;
  endtask

  task automatic run(input bit mode, input logic [7:0] v[$], input int gap);
    for (int i = 0; i < 32; i++) pk[i] = (i < v.size()) ? v[i] : 8'h00;
    model(mode);
    m32 = mode;
    for (int i = 0; i < e_len; i++) begin
      if (gap > 0 && i > 0) begin
        for (int g = 0; g < gap; g++) begin
          bv = 1'b0; bd = 8'h66;
          @(posedge clk); @(negedge clk);
          chk(done_o == 1'b0, "R13 idle cycle done", done_o, 0);
        end
      end
      bv = 1'b1; bd = pk[i];
      @(posedge clk); @(negedge clk);
      if (i != e_len - 1) chk(done_o == 1'b0, "R10 early done", done_o, 0);
      else begin
        chk(done_o == 1'b1, "R10 done pulse", done_o, 1);
        chk(len_o == 4'(e_len), "R10 length", len_o, e_len);
        chk(err_len_o == e_err, "R11 err flag", err_len_o, e_err);
        if (!e_err) begin
          chk(redundant_o == e_red, "R2 redundant", redundant_o, e_red);
          chk(seg_valid_o == e_segv, "R1 seg valid", seg_valid_o, e_segv);
          chk(seg_sel_o == e_sel, "R1 seg sel", seg_sel_o, e_sel);
          chk(opsize_o == e_ops, "R1 opsize", opsize_o, e_ops);
          chk(adsize_o == e_ads, "R1 adsize", adsize_o, e_ads);
          chk(addr32_o == e_a32, "R9 addr32", addr32_o, e_a32);
          chk(two_byte_o == e_two, "R3 two byte", two_byte_o, e_two);
          chk(opcode_o == e_op, "R3 opcode", opcode_o, e_op);
          chk(form_valid_o == e_fv, "R4 form valid", form_valid_o, e_fv);
          if (e_fv) chk(form_o == e_f, "R4 form", form_o, e_f);
          chk(sx_valid_o == e_sv, "R5 sx valid", sx_valid_o, e_sv);
          if (e_sv) chk(sx_o == e_s, "R5 sx", sx_o, e_s);
          chk(disp_len_o == 3'(e_dl), "R6 R7 disp len", disp_len_o, e_dl);
          chk(disp_o == e_d, "R8 disp", disp_o, e_d);
          chk(imm_len_o == 3'(e_il), "R8 imm len", imm_len_o, e_il);
          chk(imm_o == e_i, "R8 imm", imm_o, e_i);
        end
      end
    end
    bv = 1'b0;
  endtask

  initial begin
    logic [7:0] q[$];
    @(negedge clk);
    chk(byte_ready_o == 1'b0, "R12 ready in reset", byte_ready_o, 0);
    chk(done_o == 1'b0, "R12 done in reset", done_o, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(byte_ready_o == 1'b1, "R12 ready after reset", byte_ready_o, 1);
    chk(done_o == 1'b0, "R12 done after reset", done_o, 0);

    run(1, '{8'h90}, 0);
    run(1, '{8'h89, 8'hC3}, 0);
    run(1, '{8'h8B, 8'h04, 8'h24}, 0);
    run(1, '{8'h8B, 8'h05, 8'h78, 8'h56, 8'h34, 8'h12}, 0);
    run(1, '{8'h8B, 8'h44, 8'h24, 8'h08}, 0);
    run(1, '{8'h8B, 8'h04, 8'h25, 8'hEF, 8'hBE, 8'hAD, 8'hDE}, 0);
    run(1, '{8'h8B, 8'h84, 8'h88, 8'h01, 8'h02, 8'h03, 8'h04}, 0);
    run(1, '{8'h2E, 8'h66, 8'h81, 8'h84, 8'h88, 8'h11, 8'h22, 8'h33, 8'h44,
             8'h55, 8'h66, 8'h77, 8'h88}, 0);
    run(0, '{8'h8B, 8'h06, 8'h34, 8'h12}, 0);
    run(0, '{8'h8B, 8'h47, 8'h10}, 0);
    run(0, '{8'h8B, 8'h87, 8'h34, 8'h12}, 0);
    run(0, '{8'h8B, 8'hC0}, 0);
    run(0, '{8'h67, 8'h8B, 8'h04, 8'h24}, 0);
    run(0, '{8'h8B, 8'h04}, 0);
    run(1, '{8'h67, 8'h8B, 8'h06, 8'h34, 8'h12}, 0);
    run(1, '{8'h8B, 8'h06}, 0);
    run(1, '{8'h0F, 8'hAF, 8'hC1}, 0);
    run(1, '{8'h0F, 8'h84, 8'h10, 8'h20, 8'h30, 8'h40}, 0);
    run(1, '{8'h0F, 8'h31}, 0);
    run(1, '{8'h26, 8'h64, 8'h3E, 8'h90}, 0);
    run(1, '{8'h65, 8'h04, 8'h7F}, 0);
    run(1, '{8'h36, 8'h67, 8'h66, 8'hC2, 8'hCD, 8'hAB}, 0);
    run(1, '{8'h66, 8'h66, 8'h05, 8'h01, 8'h00, 8'h00, 8'h80}, 0);
    run(1, '{8'hC7, 8'h45, 8'hF8, 8'h11, 8'h22, 8'h33, 8'h44}, 2);
    run(1, '{8'h83, 8'h44, 8'h8D, 8'h10, 8'hFF}, 1);
    // exactly 15 bytes
    run(1, '{8'h2E, 8'h66, 8'h36, 8'h66, 8'h81, 8'h84, 8'h88, 8'h01, 8'h02,
             8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08}, 0);
    // over-length: only prefixes
    q = {};
    for (int i = 0; i < 15; i++) q.push_back(8'h2E);
    run(1, q, 0);
    run(1, '{8'h90}, 0);
    // over-length: prefixes then a long tail
    q = {};
    for (int i = 0; i < 13; i++) q.push_back(8'h66);
    q.push_back(8'h81); q.push_back(8'h84); q.push_back(8'h88);
    for (int i = 0; i < 8; i++) q.push_back(8'hA5);
    run(1, q, 0);
    run(1, '{8'h89, 8'hC3}, 0);

    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk(done_o == 1'b0, "R13 idle after stream", done_o, 0);
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule